// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block turns single-beat read and write requests from inside the chip into cycles on an external bus. The bus has 32 data pins, which can also carry the address (multiplexed arrangement), or act only as a data bus next to a separate address port (non-multiplexed arrangement). Six chip-select regions are configured by static inputs. Each region has a base address, an address mask, a port width of 8, 16 or 32 bits, and a byte-enable policy. A requester gives a request with a valid/ready handshake. It receives exactly one response pulse per accepted request, which carries either read data or an error flag.

The controller is built around four states. `ST_IDLE` waits for a request. `ST_ADDR` is the single address clock. `ST_DATA` lasts for a fixed count of data clocks, two by default. `ST_RECOVER` is one quiet clock before the bus returns to `ST_IDLE`. The transitions are as follows. *accept-hit* goes from IDLE to ADDR when a request matches a region. *accept-miss* stays in IDLE and answers with an error. *enter-data* goes from ADDR to DATA. *data-step* goes from DATA to DATA while data clocks remain. *finish* goes from DATA to RECOVER on the last data clock, where read data is captured. *release* goes from RECOVER to IDLE.

Port-width codes on `cs_psize` are: 2'b00 = 32 bits, 2'b01 = 8 bits, 2'b10 = 16 bits, and 2'b11 is treated as 32 bits. Data always sits on the upper byte lanes of the pins. Lane 3 is pins 31..24 and is enable bit 3.

Top module: `xbus_mux_ctrl`

## Requirements
- R1: Region i matches when `((addr ^ base_i) & ~mask_i) == 0`, where a mask bit of 1 means that address bit is ignored. When several regions match, the lowest index wins. Only the winning bit of `bus_cs_o` is high, during the address clock and every data clock.
- R2: A request that matches no region starts no bus cycle. One clock after acceptance, `rsp_valid` and `rsp_err` are both high and `rsp_rdata` is 0.
- R3: The accepting edge is followed by exactly 1 address clock, then 2 data clocks, then 1 recovery clock. `req_ready` is low from the address clock through the recovery clock. `rsp_valid` (with `rsp_err` low) is high only in the recovery clock.
- R4: In multiplexed mode, the address clock drives the full 32-bit address on `bus_ad_o`, and all four bits of `bus_ad_oe_o` are high.
- R5: In multiplexed mode, the pins that carry no data keep driving the low address during the data clocks, and they are enabled. For an 8-bit port, bits 23..0 carry addr[23:0]. For a 16-bit port, bits 15..0 carry addr[15:0].
- R6: In non-multiplexed mode, `bus_ad_o` carries only data. The lanes that carry no data are 0 and are not enabled. During the address and data clocks, `bus_addr_o` holds the transfer address.
- R7: On a write, the low-order bytes of the write data are driven on the data lanes for the whole cycle. A 32-bit port uses all pins. A 16-bit port puts wdata[15:0] on pins 31..16. An 8-bit port puts wdata[7:0] on pins 31..24.
- R8: On a read, the data lanes are not enabled. `bus_ad_i` is sampled on the last data clock, and the data lanes are returned right-justified and zero-extended on `rsp_rdata`.
- R9: During the data clocks, `bus_be_o` is high on exactly the data lanes (32-bit: 4'b1111, 16-bit: 4'b1100, 8-bit: 4'b1000). This holds for writes always, and for reads only when the region's `cs_be_wr_only` bit is 0. Otherwise `bus_be_o` is 0.
- R10: `bus_oe_o` is high only during the data clocks of a read whose address matched a region.
- R11: `bus_rnw_o` is high for a read and low for a write during the address and data clocks, and it is high at all other times.
- R12: During and after reset, and in IDLE and RECOVER, all chip selects, byte enables, `bus_oe_o` and `bus_ad_oe_o` are low. `bus_ad_o` and `bus_addr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Transfer address |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | One-clock response pulse |
| rsp_err | output | 1 | No region matched |
| rsp_rdata | output | 32 | Read data, right-justified |
| mux_mode | input | 1 | 1 = address and data share the pins |
| cs_base | input | NUM_CS*AW | Region base addresses, region i at [i*AW +: AW] |
| cs_mask | input | NUM_CS*AW | Region masks, 1 = ignore bit |
| cs_psize | input | NUM_CS*2 | Region port-width codes |
| cs_be_wr_only | input | NUM_CS | 1 = byte enables on writes only |
| bus_addr_o | output | AW | Address port for the non-multiplexed arrangement |
| bus_ad_o | output | 32 | Shared address/data pins, out value |
| bus_ad_oe_o | output | 4 | Per-lane drive enable for the pins |
| bus_ad_i | input | 32 | Shared pins, in value |
| bus_cs_o | output | NUM_CS | Chip selects, active high |
| bus_be_o | output | 4 | Byte enables, active high |
| bus_oe_o | output | 1 | Output enable, active high |
| bus_rnw_o | output | 1 | 1 = read, 0 = write |

## Verification
A corrupted state register appears at the pins in the very next clock. A stuck or skipped state shows up in three ways: as a chip select that is high in a clock where it should be low, as a missing data clock, or as a response that arrives one clock early or late. The bench catches each of these because it samples every clock of every cycle. A wrong latched region or port width appears one clock after acceptance, as the wrong chip-select bit or the wrong lane split of address and data on the pins. A bad capture register appears only at the response pulse. For that reason, reads use data patterns that differ in every byte, so a wrong lane choice changes the returned value.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    localparam int DW    = 32;
    localparam int LANES = DW / 8;

    localparam logic [1:0] PS_W32 = 2'b00;
    localparam logic [1:0] PS_W8  = 2'b01;
    localparam logic [1:0] PS_W16 = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ADDR    = 2'd1,
        ST_DATA    = 2'd2,
        ST_RECOVER = 2'd3
    } xbus_state_e;
endpackage

// File: rtl/xbus_region_dec.sv
module xbus_region_dec #(
    parameter int NUM_CS = 6,
    parameter int AW     = 32
) (
    input  logic [AW-1:0]        addr,
    input  logic [NUM_CS*AW-1:0] base,
    input  logic [NUM_CS*AW-1:0] mask,
    output logic [NUM_CS-1:0]    sel,
    output logic                 any_hit
);
    logic [NUM_CS-1:0] hit_vec;

    genvar g;
    generate
        for (g = 0; g < NUM_CS; g++) begin : g_cmp
            assign hit_vec[g] =
                (((addr ^ base[g*AW +: AW]) & ~mask[g*AW +: AW]) == '0);
        end
    endgenerate

    // Walk from the highest index down so the lowest match is kept.
    always_comb begin
        sel = '0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel    = '0;
                sel[i] = 1'b1;
            end
        end
    end

    assign any_hit = |hit_vec;
endmodule

// File: rtl/xbus_lane_fmt.sv
module xbus_lane_fmt
    import xbus_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             mux_mode,
    input  logic             phase_addr,
    input  logic             phase_data,
    input  logic             write,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic [1:0]       psize,
    input  logic [DW-1:0]    ad_in,
    output logic [DW-1:0]    ad_out,
    output logic [LANES-1:0] ad_oe,
    output logic [LANES-1:0] data_lanes,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] data_word;
    logic [DW-1:0] addr_fill;
    logic [DW-1:0] addr_full;

    always_comb begin
        addr_full = '0;
        for (int b = 0; b < DW && b < AW; b++) addr_full[b] = addr[b];
    end

    always_comb begin
        unique case (psize)
            PS_W8: begin
                data_lanes = 4'b1000;
                data_word  = {wdata[7:0], 24'h0};
                addr_fill  = {8'h0, addr_full[23:0]};
                rdata      = {24'h0, ad_in[31:24]};
            end
            PS_W16: begin
                data_lanes = 4'b1100;
                data_word  = {wdata[15:0], 16'h0};
                addr_fill  = {16'h0, addr_full[15:0]};
                rdata      = {16'h0, ad_in[31:16]};
            end
            default: begin
                data_lanes = 4'b1111;
                data_word  = wdata;
                addr_fill  = '0;
                rdata      = ad_in;
            end
        endcase
    end

    always_comb begin
        ad_out = '0;
        ad_oe  = '0;
        if (phase_addr && mux_mode) begin
            ad_out = addr_full;
            ad_oe  = '1;
        end else if (phase_addr || phase_data) begin
            if (write) begin
                ad_out = data_word;
                ad_oe  = data_lanes;
            end
            if (mux_mode) begin
                ad_out = ad_out | addr_fill;
                ad_oe  = ad_oe | ~data_lanes;
            end
        end
    end
endmodule

// File: rtl/xbus_mux_ctrl.sv
module xbus_mux_ctrl
    import xbus_pkg::*;
#(
    parameter int NUM_CS    = 6,
    parameter int AW        = 32,
    parameter int DATA_CLKS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [AW-1:0]        req_addr,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [31:0]          rsp_rdata,
    input  logic                 mux_mode,
    input  logic [NUM_CS*AW-1:0] cs_base,
    input  logic [NUM_CS*AW-1:0] cs_mask,
    input  logic [NUM_CS*2-1:0]  cs_psize,
    input  logic [NUM_CS-1:0]    cs_be_wr_only,
    output logic [AW-1:0]        bus_addr_o,
    output logic [31:0]          bus_ad_o,
    output logic [3:0]           bus_ad_oe_o,
    input  logic [31:0]          bus_ad_i,
    output logic [NUM_CS-1:0]    bus_cs_o,
    output logic [3:0]           bus_be_o,
    output logic                 bus_oe_o,
    output logic                 bus_rnw_o
);
    localparam int CW = (DATA_CLKS > 1) ? $clog2(DATA_CLKS) : 1;
    localparam logic [CW-1:0] LAST_DATA = CW'(DATA_CLKS - 1);

    xbus_state_e state, state_nx;
    logic [CW-1:0] dcnt, dcnt_nx;

    logic [NUM_CS-1:0] dec_sel;
    logic              dec_hit;
    logic [1:0]        sel_psize;
    logic              sel_wro;

    logic              cur_write;
    logic [AW-1:0]     cur_addr;
    logic [DW-1:0]     cur_wdata;
    logic [1:0]        cur_psize;
    logic              cur_wro;
    logic [NUM_CS-1:0] cur_cs;

    logic              in_cycle;
    logic              last_data;
    logic [DW-1:0]     fmt_rdata;
    logic [LANES-1:0]  fmt_lanes;

    xbus_region_dec #(.NUM_CS(NUM_CS), .AW(AW)) u_dec (
        .addr    (req_addr),
        .base    (cs_base),
        .mask    (cs_mask),
        .sel     (dec_sel),
        .any_hit (dec_hit)
    );

    always_comb begin
        sel_psize = PS_W32;
        sel_wro   = 1'b0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (dec_sel[i]) begin
                sel_psize = cs_psize[i*2 +: 2];
                sel_wro   = cs_be_wr_only[i];
            end
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign in_cycle  = (state == ST_ADDR) || (state == ST_DATA);
    assign last_data = (state == ST_DATA) && (dcnt == LAST_DATA);

    // Next-state logic
    always_comb begin
        state_nx = state;
        dcnt_nx  = dcnt;
        unique case (state)
            ST_IDLE:    if (req_valid && dec_hit) state_nx = ST_ADDR;
            ST_ADDR: begin
                state_nx = ST_DATA;
                dcnt_nx  = '0;
            end
            ST_DATA: begin
                if (dcnt == LAST_DATA) state_nx = ST_RECOVER;
                else                   dcnt_nx  = dcnt + 1'b1;
            end
            ST_RECOVER: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            dcnt  <= '0;
        end else begin
            state <= state_nx;
            dcnt  <= dcnt_nx;
        end
    end

    // Request latch and response register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_write <= 1'b0;
            cur_addr  <= '0;
            cur_wdata <= '0;
            cur_psize <= PS_W32;
            cur_wro   <= 1'b0;
            cur_cs    <= '0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            if (state == ST_IDLE && req_valid) begin
                if (dec_hit) begin
                    cur_write <= req_write;
                    cur_addr  <= req_addr;
                    cur_wdata <= req_wdata;
                    cur_psize <= sel_psize;
                    cur_wro   <= sel_wro;
                    cur_cs    <= dec_sel;
                end else begin
                    rsp_valid <= 1'b1;
                    rsp_err   <= 1'b1;
                    rsp_rdata <= '0;
                end
            end
            if (last_data) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= cur_write ? '0 : fmt_rdata;
            end
        end
    end

    xbus_lane_fmt #(.AW(AW)) u_fmt (
        .mux_mode   (mux_mode),
        .phase_addr (state == ST_ADDR),
        .phase_data (state == ST_DATA),
        .write      (cur_write),
        .addr       (cur_addr),
        .wdata      (cur_wdata),
        .psize      (cur_psize),
        .ad_in      (bus_ad_i),
        .ad_out     (bus_ad_o),
        .ad_oe      (bus_ad_oe_o),
        .data_lanes (fmt_lanes),
        .rdata      (fmt_rdata)
    );

    // Output process
    always_comb begin
        bus_cs_o   = in_cycle ? cur_cs : '0;
        bus_addr_o = in_cycle ? cur_addr : '0;
        bus_rnw_o  = in_cycle ? ~cur_write : 1'b1;
        bus_oe_o   = (state == ST_DATA) && !cur_write;
        bus_be_o   = ((state == ST_DATA) && (cur_write || !cur_wro)) ? fmt_lanes : '0;
    end

    // Assertions
    a_r10_oe_read_hit: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> (bus_rnw_o && bus_cs_o != '0));
    a_r1_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_cs_o));
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_cycle |-> (bus_cs_o == '0 && !bus_oe_o && bus_be_o == '0
                       && bus_rnw_o && bus_ad_oe_o == '0));
    a_r3_cs_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> $stable(bus_cs_o));
    a_r9_be_policy: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_be_o != '0 && bus_rnw_o) |-> !cur_wro);
    a_r2_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);
    a_r3_rsp_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |-> (state == ST_RECOVER));
endmodule

// File: tb/xbus_mux_ctrl_bench.sv
module xbus_mux_ctrl_bench;
    localparam int NCS = 6;
    localparam int AW  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    logic            req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [31:0]     req_wdata = '0;
    logic            req_ready, rsp_valid, rsp_err;
    logic [31:0]     rsp_rdata;
    logic            mux_mode = 1'b1;
    logic [NCS*AW-1:0] cs_base, cs_mask;
    logic [NCS*2-1:0]  cs_psize;
    logic [NCS-1:0]    cs_be_wr_only;
    logic [AW-1:0]   bus_addr_o;
    logic [31:0]     bus_ad_o, bus_ad_i = '0;
    logic [3:0]      bus_ad_oe_o, bus_be_o;
    logic [NCS-1:0]  bus_cs_o;
    logic            bus_oe_o, bus_rnw_o;

    xbus_mux_ctrl #(.NUM_CS(NCS), .AW(AW), .DATA_CLKS(2)) u_xbus_mux_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mux_mode(mux_mode), .cs_base(cs_base), .cs_mask(cs_mask),
        .cs_psize(cs_psize), .cs_be_wr_only(cs_be_wr_only),
        .bus_addr_o(bus_addr_o), .bus_ad_o(bus_ad_o), .bus_ad_oe_o(bus_ad_oe_o),
        .bus_ad_i(bus_ad_i), .bus_cs_o(bus_cs_o), .bus_be_o(bus_be_o),
        .bus_oe_o(bus_oe_o), .bus_rnw_o(bus_rnw_o)
    );

    // Region table: base, mask, width code, write-only enables
    logic [31:0] t_base [NCS] = '{32'h1000_0000, 32'h2000_0000, 32'h3000_0000,
                                  32'h1000_0000, 32'h4000_0000, 32'h5000_0000};
    logic [31:0] t_mask [NCS] = '{32'h00FF_FFFF, 32'h0000_FFFF, 32'h000F_FFFF,
                                  32'h0FFF_FFFF, 32'h0000_0000, 32'h0000_00FF};
    logic [1:0]  t_ps   [NCS] = '{2'b00, 2'b10, 2'b01, 2'b10, 2'b00, 2'b01};
    logic        t_wro  [NCS] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};

    always_comb begin
        for (int i = 0; i < NCS; i++) begin
            cs_base[i*AW +: AW]  = t_base[i];
            cs_mask[i*AW +: AW]  = t_mask[i];
            cs_psize[i*2 +: 2]   = t_ps[i];
            cs_be_wr_only[i]     = t_wro[i];
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Scoreboard
    typedef struct { bit err; logic [31:0] rdata; } rsp_t;
    rsp_t exp_q[$];

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected response", {31'h0, rsp_valid}, 32'h0);
            end else begin
                rsp_t e;
                e = exp_q.pop_front();
                chk(rsp_err == e.err, "R2 response error flag", {31'h0, rsp_err}, {31'h0, e.err});
                chk(rsp_rdata === e.rdata, "R8 response data", rsp_rdata, e.rdata);
            end
        end
    end

    function automatic int find_region(input logic [31:0] a);
        for (int i = 0; i < NCS; i++)
            if (((a ^ t_base[i]) & ~t_mask[i]) == 32'h0) return i;
        return -1;
    endfunction

    function automatic logic [3:0] lanes_of(input logic [1:0] ps);
        return (ps == 2'b01) ? 4'b1000 : (ps == 2'b10) ? 4'b1100 : 4'b1111;
    endfunction

    task automatic xfer(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                        input logic [31:0] mem);
        int r;
        logic [1:0] ps;
        logic [3:0] ln;
        logic [31:0] dw, af, exp_ad, rd;
        logic [3:0] exp_oe, exp_be;
        logic [NCS-1:0] exp_cs;
        rsp_t e;
        r = find_region(a);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; bus_ad_i = mem;
        if (r < 0) begin
            e.err = 1'b1; e.rdata = 32'h0; exp_q.push_back(e);
            @(negedge clk);
            req_valid = 1'b0;
            chk(bus_cs_o == '0, "R2 no chip select on miss", 32'(bus_cs_o), 32'h0);
            chk(req_ready == 1'b1, "R2 no cycle started", {31'h0, req_ready}, 32'h1);
            return;
        end
        ps = t_ps[r];
        ln = lanes_of(ps);
        exp_cs = '0; exp_cs[r] = 1'b1;
        case (ps)
            2'b01:   begin dw = {wd[7:0], 24'h0};  af = {8'h0, a[23:0]};  rd = {24'h0, mem[31:24]}; end
            2'b10:   begin dw = {wd[15:0], 16'h0}; af = {16'h0, a[15:0]}; rd = {16'h0, mem[31:16]}; end
            default: begin dw = wd;                af = 32'h0;            rd = mem;                 end
        endcase
        e.err = 1'b0; e.rdata = wr ? 32'h0 : rd; exp_q.push_back(e);
        exp_ad = (wr ? dw : 32'h0) | (mux_mode ? af : 32'h0);
        exp_oe = (wr ? ln : 4'h0) | (mux_mode ? ~ln : 4'h0);
        exp_be = (wr || !t_wro[r]) ? ln : 4'h0;

        // Address clock
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_cs_o == exp_cs, "R1 chip select in address clock", 32'(bus_cs_o), 32'(exp_cs));
        chk(req_ready == 1'b0, "R3 busy in address clock", {31'h0, req_ready}, 32'h0);
        chk(bus_rnw_o == !wr, "R11 read/write line", {31'h0, bus_rnw_o}, {31'h0, !wr});
        chk(bus_oe_o == 1'b0 && bus_be_o == 4'h0, "R10 R9 quiet in address clock",
            {27'h0, bus_oe_o, bus_be_o}, 32'h0);
        if (mux_mode) begin
            chk(bus_ad_o == a && bus_ad_oe_o == 4'hF, "R4 full address on pins", bus_ad_o, a);
        end else begin
            chk(bus_ad_o == (wr ? dw : 32'h0), "R6 pins carry data only", bus_ad_o, wr ? dw : 32'h0);
            chk(bus_addr_o == a, "R6 address port", bus_addr_o, a);
        end
        // Data clocks
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            chk(bus_cs_o == exp_cs, "R1 chip select in data clock", 32'(bus_cs_o), 32'(exp_cs));
            chk(bus_ad_o == exp_ad, wr ? "R7 R5 data-phase pins" : "R5 R8 data-phase pins",
                bus_ad_o, exp_ad);
            chk(bus_ad_oe_o == exp_oe, "R8 R5 lane drive enables", 32'(bus_ad_oe_o), 32'(exp_oe));
            chk(bus_be_o == exp_be, "R9 byte enables", 32'(bus_be_o), 32'(exp_be));
            chk(bus_oe_o == !wr, "R10 output enable", {31'h0, bus_oe_o}, {31'h0, !wr});
            chk(req_ready == 1'b0, "R3 busy in data clock", {31'h0, req_ready}, 32'h0);
        end
        // Recovery clock
        @(negedge clk);
        chk(bus_cs_o == '0 && bus_ad_oe_o == 4'h0 && bus_rnw_o, "R12 quiet in recovery",
            {bus_rnw_o, 27'h0, bus_ad_oe_o}, 32'h8000_0000);
        chk(rsp_valid == 1'b1, "R3 response in recovery clock", {31'h0, rsp_valid}, 32'h1);
        chk(req_ready == 1'b0, "R3 busy in recovery clock", {31'h0, req_ready}, 32'h0);
        @(negedge clk);
        chk(req_ready == 1'b1, "R3 idle after recovery", {31'h0, req_ready}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(bus_cs_o == '0 && bus_be_o == 4'h0 && !bus_oe_o && bus_ad_oe_o == 4'h0
            && bus_ad_o == 32'h0 && bus_addr_o == '0, "R12 outputs during reset",
            {bus_ad_oe_o, bus_be_o, 24'(bus_cs_o)}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && bus_rnw_o && !rsp_valid, "R12 idle after reset",
            {29'h0, req_ready, bus_rnw_o, rsp_valid}, 32'h6);

        mux_mode = 1'b1;
        xfer(1'b1, 32'h1012_3454, 32'hA1B2_C3D4, 32'h0);          // R1 region 0 wins over 3
        xfer(1'b0, 32'h1034_5678, 32'h0, 32'h8765_4321);          // 32-bit read
        xfer(1'b0, 32'h1F00_0010, 32'h0, 32'hCAFE_F00D);          // only region 3 matches, 16-bit
        xfer(1'b1, 32'h2000_ABCD, 32'h1111_5A5A, 32'h0);          // 16-bit write, R5
        xfer(1'b0, 32'h2000_0102, 32'h0, 32'hBEEF_1234);          // 16-bit read, write-only BE
        xfer(1'b1, 32'h300A_BCDE, 32'h0000_00E7, 32'h0);          // 8-bit write
        xfer(1'b0, 32'h3001_2345, 32'h0, 32'h9C33_2211);          // 8-bit read, BE on reads
        xfer(1'b0, 32'h5000_0033, 32'h0, 32'h7E00_0000);          // 8-bit read, write-only BE
        xfer(1'b0, 32'h4000_0000, 32'h0, 32'h0BAD_CAFE);          // exact-match region 4
        xfer(1'b0, 32'h4000_0004, 32'h0, 32'h0);                  // R2 mask 0 excludes
        xfer(1'b1, 32'h6000_0000, 32'h1234_5678, 32'h0);          // R2 miss
        mux_mode = 1'b0;
        xfer(1'b1, 32'h2000_0042, 32'hFFFF_9876, 32'h0);          // R6 non-mux write
        xfer(1'b0, 32'h3000_0007, 32'h0, 32'h4455_6677);          // R6 non-mux read
        xfer(1'b0, 32'h1000_0100, 32'h0, 32'h1357_9BDF);          // R6 32-bit read
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R3 every request answered", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R3 watchdog expired", 32'h0, 32'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule